// File: doc/BRIEF.md
# LCD Drive Level Encoder

This block turns the scan state of a dot-matrix LCD driver into rail selections for its output stage. Each cycle it takes the row being scanned, the display word for that row, the frame phase, a blank request and a static-reset request. From these it produces one 2-bit code for each of 16 common outputs and 64 segment outputs. Each code tells an analog switch which of four rails to connect: the top rail, the bottom rail, or one of two intermediate rails that belong to that output type.

Commons and segments each have their own pair of intermediate rails. Commons use the first and fourth, segments the second and third. Both pairs trade places when the frame phase flips, so the panel sees an AC drive. A static-reset request parks every output on a fixed, non-scanning pattern. A blank request turns every segment to its off level but lets the commons keep scanning. All outputs are registered.

Top module: `lcd_level_encoder`

## Requirements
- R1: Each output carries a 2-bit code. 00 means the bottom rail and 11 means the top rail. 01 means the lower intermediate rail of that output type: the fourth rail for a common, the third for a segment. 10 means the upper intermediate rail: the first for a common, the second for a segment.
- R2: Outputs are registered. A change at the inputs shows at the outputs only after the next rising clock edge, and not before it.
- R3: While `rst_n` is low, every common and segment code is 01, with no clock needed.
- R4: In frame A (`frame_b` = 0), with no reset request, the common whose index equals `row_sel` is 11 and every other common is 01.
- R5: In frame B (`frame_b` = 1), with no reset request, the selected common is 00 and every other common is 10.
- R6: In frame A, with no blank and no reset request, a segment whose data bit is 1 is 00 and a segment whose bit is 0 is 10.
- R7: In frame B, with no blank and no reset request, a segment whose data bit is 1 is 11 and a segment whose bit is 0 is 01.
- R8: While `blank` is high and there is no reset request, every segment takes the off code of the current frame: 10 in frame A and 01 in frame B. The commons keep scanning as in R4 and R5.
- R9: While `por_req` is high, every common and every segment is 01, whatever the values of `blank`, `frame_b`, `row_sel` and `seg_word`.
- R10: Segment output k occupies bits [2k+1:2k] of `seg_lvl` and follows bit k of `seg_word`. Common j occupies bits [2j+1:2j] of `com_lvl`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_sel | input | ROW_W (4) | Index of the common being scanned |
| seg_word | input | N_SEG (64) | Display bits for the scanned row, 1 = on |
| frame_b | input | 1 | Frame phase, 0 = frame A, 1 = frame B |
| blank | input | 1 | Forces all segments to their off level |
| por_req | input | 1 | Static reset request, parks all outputs |
| com_lvl | output | 2*N_COM (32) | Level codes of the commons |
| seg_lvl | output | 2*N_SEG (64*2) | Level codes of the segments |

## Verification
The assertions check four things on every cycle. Exactly one common is on a select rail whenever no reset request was present. A reset request leaves every output on its lower intermediate rail. Blank leaves no segment on a select rail. Outside blank, the set of segments on select rails equals the data word of the previous cycle. Some properties concern exact rail polarity and bit placement: which rail a frame phase picks, the position of each segment within the bus, and the asynchronous reset. These, together with the one-cycle latency, are shown only by the bench scenarios. Those scenarios walk a row through every common and a single bit through every segment, and they mix blank, reset request and both frame phases against a behavioural model.

// File: rtl/lcd_lvl_pkg.sv
package lcd_lvl_pkg;

  typedef logic [1:0] lvl_t;

  // rail codes shared by commons and segments
  localparam lvl_t LVL_BOT    = 2'b00;
  localparam lvl_t LVL_LO_MID = 2'b01;
  localparam lvl_t LVL_HI_MID = 2'b10;
  localparam lvl_t LVL_TOP    = 2'b11;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_BLANK  = 2'd1,
    MODE_SCAN   = 2'd2
  } drv_mode_e;

endpackage

// File: rtl/lcd_mode_ctrl.sv
module lcd_mode_ctrl
  import lcd_lvl_pkg::*;
(
  input  logic      por_req,
  input  logic      blank,
  input  logic      frame_b,
  output drv_mode_e mode,
  output logic      phase_b
);

  // reset request outranks blank, blank outranks normal scanning
  always_comb begin
    if (por_req)    mode = MODE_STATIC;
    else if (blank) mode = MODE_BLANK;
    else            mode = MODE_SCAN;
  end

  assign phase_b = frame_b;

endmodule

// File: rtl/lcd_com_enc.sv
module lcd_com_enc
  import lcd_lvl_pkg::*;
#(
  parameter int N_COM = 16,
  parameter int ROW_W = $clog2(N_COM)
)(
  input  logic [ROW_W-1:0]   row_sel,
  input  drv_mode_e          mode,
  input  logic               phase_b,
  output logic [2*N_COM-1:0] com_nxt
);

  localparam lvl_t SEL_A   = LVL_TOP;
  localparam lvl_t SEL_B   = LVL_BOT;
  localparam lvl_t UNSEL_A = LVL_LO_MID;
  localparam lvl_t UNSEL_B = LVL_HI_MID;

  for (genvar gi = 0; gi < N_COM; gi++) begin : g_com
    lvl_t code;
    always_comb begin
      if (mode == MODE_STATIC)
        code = LVL_LO_MID;
      else if (row_sel == ROW_W'(gi))
        code = phase_b ? SEL_B : SEL_A;
      else
        code = phase_b ? UNSEL_B : UNSEL_A;
    end
    assign com_nxt[2*gi +: 2] = code;
  end

endmodule

// File: rtl/lcd_seg_enc.sv
module lcd_seg_enc
  import lcd_lvl_pkg::*;
#(
  parameter int N_SEG = 64
)(
  input  logic [N_SEG-1:0]   seg_word,
  input  drv_mode_e          mode,
  input  logic               phase_b,
  output logic [2*N_SEG-1:0] seg_nxt
);

  // on level sits opposite the selected common of the same frame
  localparam lvl_t ON_A  = LVL_BOT;
  localparam lvl_t ON_B  = LVL_TOP;
  localparam lvl_t OFF_A = LVL_HI_MID;
  localparam lvl_t OFF_B = LVL_LO_MID;

  for (genvar gk = 0; gk < N_SEG; gk++) begin : g_seg
    lvl_t code;
    logic lit;
    assign lit = seg_word[gk] && (mode == MODE_SCAN);
    always_comb begin
      if (mode == MODE_STATIC)
        code = LVL_LO_MID;
      else if (lit)
        code = phase_b ? ON_B : ON_A;
      else
        code = phase_b ? OFF_B : OFF_A;
    end
    assign seg_nxt[2*gk +: 2] = code;
  end

endmodule

// File: rtl/lcd_level_encoder.sv
module lcd_level_encoder
  import lcd_lvl_pkg::*;
#(
  parameter int N_COM = 16,
  parameter int N_SEG = 64,
  parameter int ROW_W = $clog2(N_COM)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROW_W-1:0]   row_sel,
  input  logic [N_SEG-1:0]   seg_word,
  input  logic               frame_b,
  input  logic               blank,
  input  logic               por_req,
  output logic [2*N_COM-1:0] com_lvl,
  output logic [2*N_SEG-1:0] seg_lvl
);

  localparam int COM_BITS = 2 * N_COM;
  localparam int SEG_BITS = 2 * N_SEG;

  drv_mode_e            mode;
  logic                 phase_b;
  logic [COM_BITS-1:0]  com_nxt;
  logic [SEG_BITS-1:0]  seg_nxt;
  logic [COM_BITS-1:0]  com_q;
  logic [SEG_BITS-1:0]  seg_q;

  lcd_mode_ctrl u_mode (
    .por_req (por_req),
    .blank   (blank),
    .frame_b (frame_b),
    .mode    (mode),
    .phase_b (phase_b)
  );

  lcd_com_enc #(.N_COM(N_COM), .ROW_W(ROW_W)) u_com (
    .row_sel (row_sel),
    .mode    (mode),
    .phase_b (phase_b),
    .com_nxt (com_nxt)
  );

  lcd_seg_enc #(.N_SEG(N_SEG)) u_seg (
    .seg_word (seg_word),
    .mode     (mode),
    .phase_b  (phase_b),
    .seg_nxt  (seg_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      com_q <= {N_COM{LVL_LO_MID}};
      seg_q <= {N_SEG{LVL_LO_MID}};
    end else begin
      com_q <= com_nxt;
      seg_q <= seg_nxt;
    end
  end

  assign com_lvl = com_q;
  assign seg_lvl = seg_q;

  // select-rail flags seen at the registered outputs
  logic [N_COM-1:0] com_on_rail;
  logic [N_SEG-1:0] seg_on_rail;
  for (genvar gc = 0; gc < N_COM; gc++) begin : g_crail
    assign com_on_rail[gc] = (com_q[2*gc +: 2] == LVL_TOP) || (com_q[2*gc +: 2] == LVL_BOT);
  end
  for (genvar gs = 0; gs < N_SEG; gs++) begin : g_srail
    assign seg_on_rail[gs] = (seg_q[2*gs +: 2] == LVL_TOP) || (seg_q[2*gs +: 2] == LVL_BOT);
  end

  // R9
  por_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> (com_q == {N_COM{LVL_LO_MID}}) && (seg_q == {N_SEG{LVL_LO_MID}}));

  // R4
  one_common_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_req |=> ($countones(com_on_rail) == 1));

  // R8
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !por_req) |=> (seg_on_rail == '0));

  // R6
  seg_follows_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && !por_req) |=> (seg_on_rail == $past(seg_word)));

endmodule

// File: tb/lcd_level_encoder_tb.sv
module lcd_level_encoder_tb;

  localparam int NC = 16;
  localparam int NS = 64;
  localparam int RW = 4;

  logic            clk;
  logic            rst_n;
  logic [RW-1:0]   row_sel;
  logic [NS-1:0]   seg_word;
  logic            frame_b;
  logic            blank;
  logic            por_req;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  int checks;
  int errors;

  logic [2*NC-1:0] e_com;
  logic [2*NS-1:0] e_seg;

  lcd_level_encoder #(.N_COM(NC), .N_SEG(NS), .ROW_W(RW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_sel  (row_sel),
    .seg_word (seg_word),
    .frame_b  (frame_b),
    .blank    (blank),
    .por_req  (por_req),
    .com_lvl  (com_lvl),
    .seg_lvl  (seg_lvl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference for the commons
  function automatic logic [2*NC-1:0] ref_com(int row, bit fb, bit por);
    logic [2*NC-1:0] r;
    for (int j = 0; j < NC; j++) begin
      if (por)           r[2*j +: 2] = 2'b01;
      else if (j == row) r[2*j +: 2] = fb ? 2'b00 : 2'b11;
      else               r[2*j +: 2] = fb ? 2'b10 : 2'b01;
    end
    return r;
  endfunction

  // behavioural reference for the segments
  function automatic logic [2*NS-1:0] ref_seg(logic [NS-1:0] d, bit fb, bit blk, bit por);
    logic [2*NS-1:0] r;
    for (int k = 0; k < NS; k++) begin
      if (por)                r[2*k +: 2] = 2'b01;
      else if (d[k] && !blk)  r[2*k +: 2] = fb ? 2'b11 : 2'b00;
      else                    r[2*k +: 2] = fb ? 2'b01 : 2'b10;
    end
    return r;
  endfunction

  task automatic check_com(string tag, logic [2*NC-1:0] exp);
    checks++;
    if (com_lvl !== exp) begin
      errors++;
      $display("FAIL %s commons got %h expected %h", tag, com_lvl, exp);
    end
  endtask

  task automatic check_seg(string tag, logic [2*NS-1:0] exp);
    checks++;
    if (seg_lvl !== exp) begin
      errors++;
      $display("FAIL %s segments got %h expected %h", tag, seg_lvl, exp);
    end
  endtask

  // one cycle: drive at the falling edge, confirm no early change, check after the rising edge
  task automatic step(int row, logic [NS-1:0] d, bit fb, bit blk, bit por, string tc, string ts);
    row_sel  = RW'(row);
    seg_word = d;
    frame_b  = fb;
    blank    = blk;
    por_req  = por;
    #2;
    check_com("R2", e_com);
    check_seg("R2", e_seg);
    @(posedge clk);
    e_com = ref_com(row, fb, por);
    e_seg = ref_seg(d, fb, blk, por);
    @(negedge clk);
    check_com(tc, e_com);
    check_seg(ts, e_seg);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 50000; wd++) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog got no completion expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NS-1:0] d;
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    row_sel = '0;
    seg_word = '0;
    frame_b = 1'b0;
    blank = 1'b0;
    por_req = 1'b0;
    repeat (3) @(negedge clk);
    // R3: reset state
    e_com = {NC{2'b01}};
    e_seg = {NS{2'b01}};
    check_com("R3", e_com);
    check_seg("R3", e_seg);
    rst_n = 1'b1;

    // R1: exact code of the selected common in frame A
    step(0, 64'h0, 1'b0, 1'b0, 1'b0, "R4", "R6");
    checks++;
    if (com_lvl[1:0] !== 2'b11) begin
      errors++;
      $display("FAIL R1 common0 got %b expected 11", com_lvl[1:0]);
    end

    // frame A scan over every row
    for (int r = 0; r < NC; r++) begin
      d = {$urandom, $urandom};
      step(r, d, 1'b0, 1'b0, 1'b0, "R4", "R6");
    end
    // frame B scan
    for (int r = 0; r < NC; r++) begin
      d = {$urandom, $urandom};
      step(r, d, 1'b1, 1'b0, 1'b0, "R5", "R7");
    end
    step(3, {NS{1'b1}}, 1'b1, 1'b0, 1'b0, "R5", "R7");
    step(4, {NS{1'b1}}, 1'b0, 1'b0, 1'b0, "R4", "R6");

    // walking bit across segments, walking row across commons
    for (int k = 0; k < NS; k++) begin
      d = '0;
      d[k] = 1'b1;
      step(k % NC, d, k[0], 1'b0, 1'b0, "R10", "R10");
    end

    // blank in both frames, commons still scan
    for (int r = 0; r < 8; r++) begin
      step(r, {NS{1'b1}}, r[0], 1'b1, 1'b0, r[0] ? "R5" : "R4", "R8");
    end
    step(9, 64'hA5A5_0F0F_FFFF_0001, 1'b0, 1'b1, 1'b0, "R8", "R8");

    // reset request overrides blank, frame and data
    step(5, {NS{1'b1}}, 1'b0, 1'b1, 1'b1, "R9", "R9");
    step(6, {NS{1'b1}}, 1'b1, 1'b0, 1'b1, "R9", "R9");
    step(7, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b1, 1'b1, "R9", "R9");
    step(8, 64'hFFFF_0000_FFFF_0000, 1'b0, 1'b0, 1'b0, "R4", "R6");

    // R3: asynchronous reset mid-run without a clock edge
    #3;
    rst_n = 1'b0;
    #1;
    e_com = {NC{2'b01}};
    e_seg = {NS{2'b01}};
    check_com("R3", e_com);
    check_seg("R3", e_seg);
    @(negedge clk);
    rst_n = 1'b1;
    step(2, 64'h8000_0000_0000_0001, 1'b1, 1'b0, 1'b0, "R5", "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule